// File: doc/BRIEF.md
# Prioritized Interrupter with Status Vector

This block is the requesting side of a seven-level, active-low bus interrupt scheme. An internal event pulse raises a request, and the block pulls down the one request line picked by its configured level. An interrupt handler then runs an acknowledge cycle. During that cycle the level being served is carried on a 3-bit code, and the acknowledge token travels down a slot-to-slot daisy chain.

When the token reaches this block with a matching level code and a request pending, the block answers. It places its 8-bit status/ID byte on the low data byte and asserts data acknowledge. In every other case it hands the token to the next slot.

The request is withdrawn in one of two ways, chosen by an input. In one mode it drops when the acknowledge completes. In the other it stays up until software writes a clear strobe. Bus inputs are taken as already synchronous to `clk`. All outputs change one clock after the inputs that cause them are sampled.

Top module: `irq_vectorer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, all seven request lines, `dtack_n` and `iackout_n` are high, `data_oe` is 0 and `data_o` is 0.
- R2: An `event_i` pulse with no request pending sets a request. One cycle later `irq_n[level_i-1]` is low and the other six lines are high. Bit k of `irq_n` serves level k+1, and level code 0 drives no line.
- R3: Take a cycle sampled with `iackin_n`, `as_n` and `ds0_n` all low, `ack_level` equal to `level_i`, and a request pending. One cycle later `dtack_n` is low, `data_oe` is 1, `data_o` equals `vector_i` and `iackout_n` stays high. Whenever `data_oe` is 0, `data_o` is 0.
- R4: Once `ds0_n` is sampled high during a response, the next cycle shows `dtack_n` high, `data_oe` 0 and `data_o` 0, even if `as_n` is still low.
- R5: Take a cycle sampled with `iackin_n`, `as_n` and `ds0_n` all low where the level code differs or no request is pending. One cycle later `iackout_n` is low and `dtack_n` stays high. `iackout_n` stays low until `as_n` and `ds0_n` are both sampled high, and rises one cycle after that.
- R6: With `iackin_n` high, strobes and level code cause neither `dtack_n` nor `iackout_n` to go low.
- R7: With `release_on_reg_i` = 0, the request line goes high one cycle after the strobe release that ends this block's response. `clear_i` has no effect in this mode.
- R8: With `release_on_reg_i` = 1, the request line stays low through and after the acknowledge. It goes high one cycle after a `clear_i` pulse.
- R9: An event that arrives while a request is pending is held. After release the line is high for exactly one cycle, then low again.
- R10: `dtack_n` and `iackout_n` are never low together, and at most one request line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_i | input | 3 | Configured request level, 1 to 7; 0 disables |
| vector_i | input | 8 | Status/ID byte returned on acknowledge |
| release_on_reg_i | input | 1 | 0: release on acknowledge; 1: release on clear strobe |
| event_i | input | 1 | Internal interrupt event pulse |
| clear_i | input | 1 | Software clear strobe |
| irq_n | output | 7 | Active-low request lines, bit k is level k+1 |
| iackin_n | input | 1 | Acknowledge daisy-chain input, active low |
| iackout_n | output | 1 | Acknowledge daisy-chain output, active low |
| as_n | input | 1 | Address strobe, active low |
| ds0_n | input | 1 | Low-byte data strobe, active low |
| ack_level | input | 3 | Level code carried during the acknowledge cycle |
| data_o | output | 8 | Low data byte carrying the vector |
| data_oe | output | 1 | Drive enable for `data_o` |
| dtack_n | output | 1 | Data acknowledge, active low |

## Verification
The embedded properties watch several invariants on every cycle. Acknowledge and pass-through never overlap, and at most one request line is ever low. The vector is enabled only after the data strobe was seen low. A pass-through or a response begins only after the chain input or a pending request was present. The two release policies are also checked at the moment of strobe release or clear.

Some behaviours can only be shown by the bench's sweep over every level, level code and policy. These are the exact vector value, the one-cycle gap before a held event re-raises its line, and the timing of the chain release.

// File: rtl/irq_vectorer.sv
module irq_vectorer #(
  parameter int LEVELS = 7,
  parameter int LVL_W  = 3,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  level_i,
  input  logic [VEC_W-1:0]  vector_i,
  input  logic              release_on_reg_i,
  input  logic              event_i,
  input  logic              clear_i,
  output logic [LEVELS-1:0] irq_n,
  input  logic              iackin_n,
  output logic              iackout_n,
  input  logic              as_n,
  input  logic              ds0_n,
  input  logic [LVL_W-1:0]  ack_level,
  output logic [VEC_W-1:0]  data_o,
  output logic              data_oe,
  output logic              dtack_n
);

  typedef enum logic [1:0] {S_IDLE, S_RESP, S_TAIL, S_PASS} ack_state_t;

  ack_state_t state, state_nx;
  logic pending, held;
  logic cycle_start, hit, release_now;

  assign cycle_start = !iackin_n && !as_n && !ds0_n;
  assign hit         = pending && (ack_level == level_i) && (level_i != '0);
  assign release_now = release_on_reg_i ? clear_i : (state == S_RESP && ds0_n);

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE: if (cycle_start) state_nx = hit ? S_RESP : S_PASS;
      S_RESP: if (ds0_n) state_nx = as_n ? S_IDLE : S_TAIL;
      S_TAIL: if (as_n) state_nx = S_IDLE;
      S_PASS: if (as_n && ds0_n) state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pending <= 1'b0;
      held    <= 1'b0;
    end else begin
      state <= state_nx;
      if (pending) begin
        if (event_i) held <= 1'b1;
        if (release_now) pending <= 1'b0;
      end else if (held || event_i) begin
        pending <= 1'b1;
        held    <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < LEVELS; k++) begin : g_line
    assign irq_n[k] = !(pending && level_i == LVL_W'(k + 1));
  end

  assign data_oe   = (state == S_RESP);
  assign data_o    = data_oe ? vector_i : '0;
  assign dtack_n   = !data_oe;
  assign iackout_n = !(state == S_PASS);

  assert_no_double_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !iackout_n));
  assert_single_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~irq_n));
  assert_vector_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(!ds0_n));
  assert_answer_needs_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> $past(|(~irq_n)));
  assert_pass_needs_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iackout_n) |-> $past(!iackin_n));
  assert_release_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RESP && ds0_n && !release_on_reg_i) |=> (&irq_n));
  assert_hold_until_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && release_on_reg_i && !clear_i && $stable(level_i)) |=> $stable(irq_n));

endmodule

// File: tb/irq_vectorer_tb.sv
`timescale 1ns/1ps
module irq_vectorer_tb_top;
  logic clk = 1'b0;
  logic rst_n, rora, ev, clr, iackin_n, as_n, ds0_n;
  logic [2:0] lvl, alvl;
  logic [7:0] vec;
  logic [6:0] irq_n;
  logic [7:0] data_o;
  logic data_oe, dtack_n, iackout_n;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  irq_vectorer dut_i (
    .clk(clk), .rst_n(rst_n), .level_i(lvl), .vector_i(vec),
    .release_on_reg_i(rora), .event_i(ev), .clear_i(clr), .irq_n(irq_n),
    .iackin_n(iackin_n), .iackout_n(iackout_n), .as_n(as_n), .ds0_n(ds0_n),
    .ack_level(alvl), .data_o(data_o), .data_oe(data_oe), .dtack_n(dtack_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_idle();
    iackin_n = 1; as_n = 1; ds0_n = 1; alvl = 0; ev = 0; clr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; bus_idle(); tick(); tick(); rst_n = 1;
  endtask

  task automatic pulse_event();
    ev = 1; tick(); ev = 0;
  endtask

  function automatic logic [6:0] line_of(input int l);
    return (l == 0) ? 7'h7F : (7'h7F & ~(7'd1 << (l - 1)));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    lvl = 3; vec = 8'hA5; rora = 0;
    do_reset();
    // R1: reset state
    chk(irq_n == 7'h7F, "R1 irq", irq_n, 7'h7F);
    chk(dtack_n && iackout_n && !data_oe && data_o == 0, "R1 bus", {dtack_n, iackout_n, data_oe}, 3'b110);

    // R2: level 0 drives nothing
    lvl = 0; pulse_event();
    chk(irq_n == 7'h7F, "R2 level0", irq_n, 7'h7F);

    // R5: no pending, matching code -> pass on
    do_reset(); lvl = 4; alvl = 4; iackin_n = 0; as_n = 0; ds0_n = 0; tick();
    chk(!iackout_n && dtack_n, "R5 nopend", {iackout_n, dtack_n}, 2'b01);
    as_n = 1; ds0_n = 1; iackin_n = 1; tick();
    chk(iackout_n, "R5 release", iackout_n, 1);

    // R6: chain input high -> nothing answers
    do_reset(); lvl = 5; pulse_event(); alvl = 5; as_n = 0; ds0_n = 0; tick(); tick();
    chk(iackout_n && dtack_n && !data_oe, "R6", {iackout_n, dtack_n}, 2'b11);
    bus_idle(); tick();

    // R9: held event re-raises after one idle cycle
    do_reset(); lvl = 2; rora = 0; pulse_event(); pulse_event();
    chk(irq_n == line_of(2), "R9 pend", irq_n, line_of(2));
    alvl = 2; iackin_n = 0; as_n = 0; ds0_n = 0; tick();
    ds0_n = 1; as_n = 1; iackin_n = 1; tick();
    chk(irq_n == 7'h7F, "R9 gap", irq_n, 7'h7F);
    tick();
    chk(irq_n == line_of(2), "R9 again", irq_n, line_of(2));

    // Sweep: every level x level code x policy
    for (int l = 1; l <= 7; l++)
      for (int a = 0; a <= 7; a++)
        for (int m = 0; m <= 1; m++) begin
          do_reset();
          lvl = 3'(l); rora = m[0]; vec = 8'(l * 32 + a * 2 + m);
          pulse_event();
          chk(irq_n == line_of(l), "R2 line", irq_n, line_of(l));
          if (m == 0) begin
            clr = 1; tick(); clr = 0;
            chk(irq_n == line_of(l), "R7 clear ignored", irq_n, line_of(l));
          end
          alvl = 3'(a); iackin_n = 0; as_n = 0; ds0_n = 0; tick();
          if (a == l) begin
            chk(!dtack_n && data_oe && iackout_n, "R3 answer", {dtack_n, data_oe, iackout_n}, 3'b011);
            chk(data_o == vec, "R3 vector", data_o, vec);
          end else begin
            chk(!iackout_n && dtack_n && data_o == 0, "R5 pass", {iackout_n, dtack_n}, 2'b01);
          end
          ds0_n = 1; tick();
          if (a == l) begin
            chk(dtack_n && !data_oe && data_o == 0, "R4 removed", {dtack_n, data_oe}, 2'b10);
            if (m == 0) chk(irq_n == 7'h7F, "R7 released", irq_n, 7'h7F);
            else chk(irq_n == line_of(l), "R8 kept", irq_n, line_of(l));
          end else begin
            chk(!iackout_n, "R5 held while AS low", iackout_n, 0);
            chk(irq_n == line_of(l), "R5 request kept", irq_n, line_of(l));
          end
          as_n = 1; iackin_n = 1; tick();
          chk(iackout_n && dtack_n, "R5 chain idle", {iackout_n, dtack_n}, 2'b11);
          if (a == l && m == 1) begin
            chk(irq_n == line_of(l), "R8 after ack", irq_n, line_of(l));
            clr = 1; tick(); clr = 0;
            chk(irq_n == 7'h7F, "R8 cleared", irq_n, 7'h7F);
          end
        end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule